// File: doc/BRIEF.md
# Nine-Bit Asynchronous Serial Port with Framing Check

This block is a full-duplex asynchronous serial port whose frames carry eight data bits followed by a ninth bit under software control. Software writes a byte to the transmit buffer to load and launch a frame. It reads received bytes from a receive buffer. A single eight-bit control register holds the rate source, the receive enable, both ninth bits and the transmit-done and receive-done flags.

Both directions run from one oversampling tick at sixteen times the bit rate. In fixed-rate mode the tick is derived from the system clock so that a bit lasts 16, 32 or 64 clocks. In external mode each pulse on an input tick pin counts as one oversampling tick. The receiver votes over three samples near the middle of each bit. It flags a frame whose stop bit reads low.

The top bit of the control register has two uses. A select input decides whether it holds a stored mode bit or a sticky frame-error flag. Reads and writes of that bit reach only the one currently selected.

Top module: `uart9_port`

## Requirements
- R1: A transmitted frame is 11 bit periods on `txd`: one low start bit, `buf_wdata` bit 0 through bit 7, then the value of control bit 3 (transmit ninth bit) taken when the buffer was written, then one high stop bit. `txd` is high whenever no frame is being sent.
- R2: With control bit 6 = 0, `div_sel` 0, 1 and 2 or 3 give bit periods of 16, 32 and 64 clocks. With control bit 6 = 1, one bit period is 16 pulses of `ext_tick`. Both directions use this rate.
- R3: Control bit 1 (transmit done) is still 0 while the ninth bit is on the line. It becomes 1 when the stop bit starts.
- R4: A buffer write that arrives while a frame is pending or being sent is ignored. The frame in progress is unchanged and no second frame follows it.
- R5: With control bit 4 (receive enable) = 0, frames on `rxd` change neither `rx_buf`, nor control bit 2, nor control bit 0.
- R6: With receive enable = 1, a frame that starts with a falling edge on `rxd` and is sent LSB first loads its eight data bits into `rx_buf` and its ninth bit into control bit 2. It sets control bit 0 (receive done).
- R7: If the start bit reads 1 at its midpoint vote (samples 7, 8 and 9 of 16), the receiver drops the frame and returns to idle. It sets no flag and stays ready for the next falling edge.
- R8: A stop bit that reads 0 sets the frame-error flag. Hardware never clears it. Later good frames leave it at 1, and only a control write with `fe_sel` = 1 and bit 7 = 0 clears it.
- R9: Control bit 7 reads the frame-error flag when `fe_sel` = 1 and the stored mode bit when `fe_sel` = 0. A write to bit 7 changes only the one that is selected.
- R10: A control write stores the written values of bits 0 and 1. Writing 0 clears the done flags. Bit 5 always reads 0.
- R11: After reset `txd` = 1, `ctrl_rd` = 0 and `rx_buf` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| buf_wr | input | 1 | Transmit buffer write strobe |
| buf_wdata | input | 8 | Byte to transmit |
| ctrl_wr | input | 1 | Control register write strobe |
| ctrl_wdata | input | 8 | Control register write value |
| fe_sel | input | 1 | 1: control bit 7 is the frame-error flag, 0: it is the mode bit |
| div_sel | input | 2 | Fixed-rate divider select |
| ext_tick | input | 1 | External oversampling tick, one clock wide |
| rxd | input | 1 | Serial receive line |
| txd | output | 1 | Serial transmit line |
| ctrl_rd | output | 8 | Control register read value |
| rx_buf | output | 8 | Last received byte |

## Verification
The assertions check several rules on every clock. `txd` stays high outside a frame. A buffer write during a frame leaves the transmit shift register unchanged. The transmit-done flag rises only while the stop level is on the line. The frame-error flag drops only on a selected software write. An idle receiver with reception disabled stays idle. The halved fixed rate never ticks on two clocks in a row.

Some behaviour only the bench scenarios can show. These are the exact bit order and bit periods under each divider and the external tick, and the captured byte and ninth bit. They also include the rejection of glitches, the silence while reception is disabled, and how the shared bit 7 behaves across different `fe_sel` settings.

// File: rtl/uart9_pkg.sv
package uart9_pkg;
  localparam int OVS   = 16;
  localparam int OVS_W = $clog2(OVS);
  localparam int MID   = OVS / 2;

  typedef enum logic [1:0] {
    RX_IDLE  = 2'd0,
    RX_START = 2'd1,
    RX_DATA  = 2'd2,
    RX_STOP  = 2'd3
  } rx_state_e;
endpackage

// File: rtl/uart9_tick.sv
module uart9_tick
  import uart9_pkg::*;
#(
  parameter int MAX_SHIFT = 2
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       rate_ext,
  input  logic [1:0] div_sel,
  input  logic       ext_tick,
  output logic       s_tick,
  output logic       bit_tick
);
  localparam int PRE_W = (MAX_SHIFT < 1) ? 1 : MAX_SHIFT;

  logic [PRE_W-1:0] pre_q, pre_d, lim;
  logic [OVS_W-1:0] ph_q, ph_d;
  logic [1:0]       sh_eff;
  logic             fix_tick;

  always_comb begin
    sh_eff   = (int'(div_sel) > MAX_SHIFT) ? 2'(MAX_SHIFT) : div_sel;
    lim      = PRE_W'((1 << sh_eff) - 1);
    fix_tick = (pre_q == lim);
    pre_d    = fix_tick ? '0 : pre_q + 1'b1;
    s_tick   = rate_ext ? ext_tick : fix_tick;
    ph_d     = s_tick ? ph_q + 1'b1 : ph_q;
    bit_tick = s_tick && (ph_q == OVS_W'(OVS - 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pre_q <= '0;
      ph_q  <= '0;
    end else begin
      pre_q <= pre_d;
      ph_q  <= ph_d;
    end
  end

  // R2: at the /32 setting a tick never lands on two consecutive clocks
  a_r2_half_rate: assert property (@(posedge clk) disable iff (!rst_n)
    (!rate_ext && div_sel == 2'd1 && s_tick) |=>
      (!s_tick || rate_ext || div_sel != 2'd1));
endmodule

// File: rtl/uart9_tx.sv
module uart9_tx
  import uart9_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          load,
  input  logic [DW-1:0] din,
  input  logic          b9,
  input  logic          bit_tick,
  output logic          txd,
  output logic          ti_set
);
  localparam int FRAME = DW + 3;
  localparam int IDX_W = $clog2(FRAME);

  logic [FRAME-1:0] sh_q, sh_d;
  logic [IDX_W-1:0] idx_q, idx_d;
  logic             pend_q, pend_d, busy_q, busy_d, txd_q, txd_d;

  always_comb begin
    sh_d   = sh_q;
    idx_d  = idx_q;
    pend_d = pend_q;
    busy_d = busy_q;
    txd_d  = txd_q;
    ti_set = 1'b0;
    if (load && !pend_q && !busy_q) begin
      sh_d   = {1'b1, b9, din, 1'b0};
      pend_d = 1'b1;
    end
    if (bit_tick) begin
      if (pend_q) begin
        pend_d = 1'b0;
        busy_d = 1'b1;
        txd_d  = sh_q[0];
        sh_d   = {1'b1, sh_q[FRAME-1:1]};
        idx_d  = '0;
      end else if (busy_q) begin
        if (idx_q == IDX_W'(FRAME - 1)) begin
          busy_d = 1'b0;
          txd_d  = 1'b1;
        end else begin
          txd_d  = sh_q[0];
          sh_d   = {1'b1, sh_q[FRAME-1:1]};
          idx_d  = idx_q + 1'b1;
          ti_set = (idx_q == IDX_W'(FRAME - 2));
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_q   <= '1;
      idx_q  <= '0;
      pend_q <= 1'b0;
      busy_q <= 1'b0;
      txd_q  <= 1'b1;
    end else begin
      sh_q   <= sh_d;
      idx_q  <= idx_d;
      pend_q <= pend_d;
      busy_q <= busy_d;
      txd_q  <= txd_d;
    end
  end

  assign txd = txd_q;

  // R1: line rests high outside a frame
  a_r1_idle_high: assert property (@(posedge clk) disable iff (!rst_n)
    !busy_q |-> txd_q);

  // R4: a write during a pending or active frame leaves the shift register alone
  a_r4_ignore_load: assert property (@(posedge clk) disable iff (!rst_n)
    ((pend_q || busy_q) && load && !bit_tick) |=> $stable(sh_q));
endmodule

// File: rtl/uart9_rx.sv
module uart9_rx
  import uart9_pkg::*;
#(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          en,
  input  logic          rxd,
  input  logic          s_tick,
  output logic          done,
  output logic          ferr,
  output logic [DW-1:0] dout,
  output logic          b9
);
  localparam int CNT_W = $clog2(DW + 1);

  rx_state_e        st_q, st_d;
  logic [OVS_W-1:0] ph_q, ph_d;
  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic [DW:0]      sh_q, sh_d;
  logic             rs1_q, rs2_q, last_q, last_d;
  logic             v0_q, v0_d, v1_q, v1_d, vote;

  always_comb begin
    st_d   = st_q;
    ph_d   = ph_q;
    cnt_d  = cnt_q;
    sh_d   = sh_q;
    last_d = last_q;
    v0_d   = v0_q;
    v1_d   = v1_q;
    done   = 1'b0;
    ferr   = 1'b0;
    vote   = (v0_q & v1_q) | (v0_q & rs2_q) | (v1_q & rs2_q);
    if (s_tick) begin
      last_d = rs2_q;
      if (st_q == RX_IDLE) begin
        if (en && last_q && !rs2_q) begin
          st_d = RX_START;
          ph_d = '0;
        end
      end else begin
        ph_d = ph_q + 1'b1;
        if (ph_q == OVS_W'(MID - 1)) v0_d = rs2_q;
        if (ph_q == OVS_W'(MID))     v1_d = rs2_q;
        if (ph_q == OVS_W'(MID + 1)) begin
          case (st_q)
            RX_START: if (vote) st_d = RX_IDLE;
            RX_DATA: begin
              sh_d = {vote, sh_q[DW:1]};
              done = (cnt_q == CNT_W'(DW));
            end
            RX_STOP: begin
              ferr = !vote;
              st_d = RX_IDLE;
            end
            default: ;
          endcase
        end
        if (ph_q == OVS_W'(OVS - 1)) begin
          case (st_q)
            RX_START: begin
              st_d  = RX_DATA;
              cnt_d = '0;
            end
            RX_DATA: begin
              if (cnt_q == CNT_W'(DW)) st_d = RX_STOP;
              else                     cnt_d = cnt_q + 1'b1;
            end
            default: ;
          endcase
        end
      end
    end
    dout = sh_d[DW-1:0];
    b9   = sh_d[DW];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rs1_q  <= 1'b1;
      rs2_q  <= 1'b1;
      last_q <= 1'b1;
      st_q   <= RX_IDLE;
      ph_q   <= '0;
      cnt_q  <= '0;
      sh_q   <= '0;
      v0_q   <= 1'b1;
      v1_q   <= 1'b1;
    end else begin
      rs1_q  <= rxd;
      rs2_q  <= rs1_q;
      last_q <= last_d;
      st_q   <= st_d;
      ph_q   <= ph_d;
      cnt_q  <= cnt_d;
      sh_q   <= sh_d;
      v0_q   <= v0_d;
      v1_q   <= v1_d;
    end
  end

  // R5: with reception disabled an idle receiver never leaves idle
  a_r5_stay_idle: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == RX_IDLE && !en) |=> (st_q == RX_IDLE));
endmodule

// File: rtl/uart9_port.sv
module uart9_port
  import uart9_pkg::*;
#(
  parameter int DW        = 8,
  parameter int MAX_SHIFT = 2
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          buf_wr,
  input  logic [DW-1:0] buf_wdata,
  input  logic          ctrl_wr,
  input  logic [7:0]    ctrl_wdata,
  input  logic          fe_sel,
  input  logic [1:0]    div_sel,
  input  logic          ext_tick,
  input  logic          rxd,
  output logic          txd,
  output logic [7:0]    ctrl_rd,
  output logic [DW-1:0] rx_buf
);
  logic [1:0]    rst_sync_q;
  logic          rst_i;
  logic          s_tick, bit_tick, ti_set, rx_done, rx_ferr, rx_b9;
  logic [DW-1:0] rx_dout;

  logic          sm0_q, sm0_d, fe_q, fe_d, ext_q, ext_d, ren_q, ren_d;
  logic          tb8_q, tb8_d, rb8_q, rb8_d, ti_q, ti_d, ri_q, ri_d;
  logic [DW-1:0] rbuf_q, rbuf_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_i = rst_sync_q[1];

  uart9_tick #(.MAX_SHIFT(MAX_SHIFT)) u_tick (
    .clk(clk), .rst_n(rst_i), .rate_ext(ext_q), .div_sel(div_sel),
    .ext_tick(ext_tick), .s_tick(s_tick), .bit_tick(bit_tick)
  );

  uart9_tx #(.DW(DW)) u_tx (
    .clk(clk), .rst_n(rst_i), .load(buf_wr), .din(buf_wdata), .b9(tb8_q),
    .bit_tick(bit_tick), .txd(txd), .ti_set(ti_set)
  );

  uart9_rx #(.DW(DW)) u_rx (
    .clk(clk), .rst_n(rst_i), .en(ren_q), .rxd(rxd), .s_tick(s_tick),
    .done(rx_done), .ferr(rx_ferr), .dout(rx_dout), .b9(rx_b9)
  );

  always_comb begin
    sm0_d  = sm0_q;
    fe_d   = fe_q;
    ext_d  = ext_q;
    ren_d  = ren_q;
    tb8_d  = tb8_q;
    ti_d   = ti_q;
    ri_d   = ri_q;
    rb8_d  = rb8_q;
    rbuf_d = rbuf_q;
    if (ctrl_wr) begin
      if (fe_sel) fe_d  = ctrl_wdata[7];
      else        sm0_d = ctrl_wdata[7];
      ext_d = ctrl_wdata[6];
      ren_d = ctrl_wdata[4];
      tb8_d = ctrl_wdata[3];
      ti_d  = ctrl_wdata[1];
      ri_d  = ctrl_wdata[0];
    end
    if (ti_set)  ti_d = 1'b1;
    if (rx_ferr) fe_d = 1'b1;
    if (rx_done) begin
      ri_d   = 1'b1;
      rb8_d  = rx_b9;
      rbuf_d = rx_dout;
    end
  end

  always_ff @(posedge clk or negedge rst_i) begin
    if (!rst_i) begin
      sm0_q  <= 1'b0;
      fe_q   <= 1'b0;
      ext_q  <= 1'b0;
      ren_q  <= 1'b0;
      tb8_q  <= 1'b0;
      rb8_q  <= 1'b0;
      ti_q   <= 1'b0;
      ri_q   <= 1'b0;
      rbuf_q <= '0;
    end else begin
      sm0_q  <= sm0_d;
      fe_q   <= fe_d;
      ext_q  <= ext_d;
      ren_q  <= ren_d;
      tb8_q  <= tb8_d;
      rb8_q  <= rb8_d;
      ti_q   <= ti_d;
      ri_q   <= ri_d;
      rbuf_q <= rbuf_d;
    end
  end

  assign ctrl_rd = {fe_sel ? fe_q : sm0_q, ext_q, 1'b0, ren_q, tb8_q, rb8_q, ti_q, ri_q};
  assign rx_buf  = rbuf_q;

  // R3: the done flag rises on its own only while the stop level is driven
  a_r3_ti_at_stop: assert property (@(posedge clk) disable iff (!rst_i)
    ($rose(ti_q) && !$past(ctrl_wr)) |-> txd);

  // R8: the frame-error flag survives everything except a selected software write
  a_r8_fe_sticky: assert property (@(posedge clk) disable iff (!rst_i)
    (fe_q && !(ctrl_wr && fe_sel)) |=> fe_q);
endmodule

// File: tb/uart9_port_test.sv
`timescale 1ns/1ps
module uart9_port_test;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       buf_wr, ctrl_wr, fe_sel, ext_tick, rxd;
  logic [7:0] buf_wdata, ctrl_wdata;
  logic [1:0] div_sel;
  logic       txd;
  logic [7:0] ctrl_rd, rx_buf;

  int n_chk = 0;
  int n_err = 0;
  int ext_on = 0;
  bit finished = 0;

  localparam int EXT_DIV = 3;

  always #2.5 clk = ~clk;

  uart9_port uut (
    .clk(clk), .rst_n(rst_n), .buf_wr(buf_wr), .buf_wdata(buf_wdata),
    .ctrl_wr(ctrl_wr), .ctrl_wdata(ctrl_wdata), .fe_sel(fe_sel),
    .div_sel(div_sel), .ext_tick(ext_tick), .rxd(rxd), .txd(txd),
    .ctrl_rd(ctrl_rd), .rx_buf(rx_buf)
  );

  initial begin
    int c = 0;
    ext_tick = 1'b0;
    forever begin
      @(negedge clk);
      ext_tick = (c == 0);
      c = (c == EXT_DIV - 1) ? 0 : c + 1;
    end
  end

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic int bit_period(input logic [1:0] ds, input bit ext);
    if (ext) return 16 * EXT_DIV;
    return 16 << ((ds > 2'd2) ? 2 : int'(ds));
  endfunction

  function automatic logic [10:0] frame_of(input logic [7:0] d, input logic b9, input logic stp);
    return {stp, b9, d, 1'b0};
  endfunction

  task automatic upd(input logic [7:0] mask, input logic [7:0] val);
    @(negedge clk);
    ctrl_wdata = (ctrl_rd & ~mask) | (val & mask);
    ctrl_wr = 1'b1;
    @(negedge clk);
    ctrl_wr = 1'b0;
  endtask

  task automatic tx_frame(input logic [7:0] d, input logic b9, input int p, input bit poke);
    logic [10:0] f;
    int w;
    bit seen_low;
    f = frame_of(d, b9, 1'b1);
    upd(8'h0A, {4'b0, b9, 1'b0, 1'b0, 1'b0});
    @(negedge clk);
    buf_wr = 1'b1;
    buf_wdata = d;
    @(negedge clk);
    buf_wr = 1'b0;
    w = 0;
    while (txd !== 1'b0 && w < 4 * p) begin
      @(negedge clk);
      w++;
    end
    chk("R2 frame start within a bit period", 32'(w < 4 * p), 32'd1);
    repeat (p / 2) @(negedge clk);
    for (int k = 0; k < 11; k++) begin
      chk($sformatf("R1 tx bit %0d", k), 32'(txd), 32'(f[k]));
      if (k == 9)  chk("R3 TI low during ninth bit", 32'(ctrl_rd[1]), 32'd0);
      if (k == 10) chk("R3 TI high at stop bit", 32'(ctrl_rd[1]), 32'd1);
      if (poke && k == 3) begin
        @(negedge clk);
        buf_wr = 1'b1;
        buf_wdata = ~d;
        @(negedge clk);
        buf_wr = 1'b0;
        repeat (p - 2) @(negedge clk);
      end else begin
        repeat (p) @(negedge clk);
      end
    end
    if (poke) begin
      seen_low = 0;
      for (int i = 0; i < 3 * p; i++) begin
        if (txd == 1'b0) seen_low = 1;
        @(negedge clk);
      end
      chk("R4 no frame after ignored write", 32'(seen_low), 32'd0);
    end
  endtask

  task automatic rx_frame(input logic [7:0] d, input logic b9, input logic stp, input int p);
    logic [10:0] f;
    f = frame_of(d, b9, stp);
    for (int k = 0; k < 11; k++) begin
      @(negedge clk);
      rxd = f[k];
      repeat (p - 1) @(negedge clk);
    end
    @(negedge clk);
    rxd = 1'b1;
    repeat (p) @(negedge clk);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_err++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    logic [7:0] d, prev;
    logic b9;
    logic [1:0] ds;
    int p;
    void'($urandom(32'h0C0FFEE5));
    rst_n = 1'b0; buf_wr = 1'b0; ctrl_wr = 1'b0; fe_sel = 1'b0;
    div_sel = 2'd0; rxd = 1'b1; buf_wdata = '0; ctrl_wdata = '0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R11 txd after reset", 32'(txd), 32'd1);
    chk("R11 ctrl after reset", 32'(ctrl_rd), 32'd0);
    chk("R11 rx_buf after reset", 32'(rx_buf), 32'd0);

    // directed transmit at each fixed rate, then ignored write
    tx_frame(8'hA5, 1'b1, 16, 0);
    div_sel = 2'd1;
    tx_frame(8'h3C, 1'b0, 32, 0);
    div_sel = 2'd3;
    tx_frame(8'h81, 1'b1, 64, 0);
    div_sel = 2'd0;
    tx_frame(8'h5A, 1'b0, 16, 1);

    // R10 software writes of the done flags
    upd(8'h02, 8'h02);
    chk("R10 TI written to 1", 32'(ctrl_rd[1]), 32'd1);
    upd(8'h02, 8'h00);
    chk("R10 TI cleared", 32'(ctrl_rd[1]), 32'd0);
    upd(8'h20, 8'h20);
    chk("R10 bit 5 reads 0", 32'(ctrl_rd[5]), 32'd0);

    // R5 receive disabled
    rx_frame(8'hC3, 1'b1, 1'b1, 16);
    chk("R5 RI unchanged while disabled", 32'(ctrl_rd[0]), 32'd0);
    chk("R5 RB8 unchanged while disabled", 32'(ctrl_rd[2]), 32'd0);
    chk("R5 rx_buf unchanged while disabled", 32'(rx_buf), 32'd0);

    // R6 enabled reception
    upd(8'h10, 8'h10);
    rx_frame(8'h96, 1'b1, 1'b1, 16);
    chk("R6 rx data", 32'(rx_buf), 32'h96);
    chk("R6 RB8", 32'(ctrl_rd[2]), 32'd1);
    chk("R6 RI set", 32'(ctrl_rd[0]), 32'd1);
    upd(8'h01, 8'h00);
    chk("R10 RI cleared", 32'(ctrl_rd[0]), 32'd0);

    // R7 glitch on the line
    @(negedge clk);
    rxd = 1'b0;
    repeat (3) @(negedge clk);
    rxd = 1'b1;
    repeat (40) @(negedge clk);
    chk("R7 no RI after false start", 32'(ctrl_rd[0]), 32'd0);
    chk("R7 rx_buf kept after false start", 32'(rx_buf), 32'h96);
    rx_frame(8'h4E, 1'b0, 1'b1, 16);
    chk("R7 next frame received", 32'(rx_buf), 32'h4E);
    chk("R7 next frame RB8", 32'(ctrl_rd[2]), 32'd0);

    // R8 / R9 frame error and the shared bit
    fe_sel = 1'b1;
    upd(8'h01, 8'h00);
    chk("R9 FE view starts clear", 32'(ctrl_rd[7]), 32'd0);
    rx_frame(8'h21, 1'b1, 1'b0, 16);
    chk("R8 FE set by low stop", 32'(ctrl_rd[7]), 32'd1);
    chk("R6 data kept with bad stop", 32'(rx_buf), 32'h21);
    fe_sel = 1'b0;
    @(negedge clk);
    chk("R9 mode view while FE set", 32'(ctrl_rd[7]), 32'd0);
    upd(8'h80, 8'h80);
    chk("R9 mode bit written", 32'(ctrl_rd[7]), 32'd1);
    fe_sel = 1'b1;
    rx_frame(8'h7E, 1'b0, 1'b1, 16);
    chk("R8 FE held over good frame", 32'(ctrl_rd[7]), 32'd1);
    upd(8'h80, 8'h00);
    chk("R8 FE cleared by write", 32'(ctrl_rd[7]), 32'd0);
    fe_sel = 1'b0;
    @(negedge clk);
    chk("R9 mode bit untouched by FE write", 32'(ctrl_rd[7]), 32'd1);

    // R2 external tick source, both directions
    upd(8'h40, 8'h40);
    p = bit_period(2'd0, 1);
    tx_frame(8'hE7, 1'b1, p, 0);
    rx_frame(8'h18, 1'b1, 1'b1, p);
    chk("R2 ext rate rx data", 32'(rx_buf), 32'h18);
    chk("R2 ext rate RB8", 32'(ctrl_rd[2]), 32'd1);
    upd(8'h40, 8'h00);

    // random frames on the fixed rates
    for (int i = 0; i < 5; i++) begin
      d  = 8'($urandom);
      b9 = 1'($urandom);
      ds = 2'($urandom);
      div_sel = ds;
      p = bit_period(ds, 0);
      tx_frame(d, b9, p, 0);
    end
    for (int i = 0; i < 5; i++) begin
      d  = 8'($urandom);
      b9 = 1'($urandom);
      ds = 2'($urandom);
      div_sel = ds;
      p = bit_period(ds, 0);
      upd(8'h01, 8'h00);
      prev = d;
      rx_frame(d, b9, 1'b1, p);
      chk("R6 random rx data", 32'(rx_buf), 32'(prev));
      chk("R6 random RB8", 32'(ctrl_rd[2]), 32'(b9));
      chk("R6 random RI", 32'(ctrl_rd[0]), 32'd1);
    end

    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule